// File: doc/BRIEF.md
# Pipelined Single-Bit Sorting Network

This block applies a host-programmed list of compare-exchange operations to a vector of single-bit lanes. It has a fixed number of pipeline stages, one operation per stage. Each stage holds a pair of lane numbers. The lower-numbered lane of the pair takes the AND of the two bits, the higher-numbered lane takes the OR, and every other lane passes straight through. The effect is that a zero moves toward the low lane and a one toward the high lane.

Every stage is registered. A new vector can therefore enter on every clock, and a full pipeline holds one vector per stage. A valid flag moves alongside each vector, so downstream logic can tell real results from the zeros left behind by a reset or clear. The host loads each stage through a narrow write port. Writes take effect only while nothing valid is in flight, so a vector never sees a stage list that changes partway through.

A typical use is scoring a candidate network. The candidate is loaded, every binary input pattern is streamed through at one per clock, and each output is compared against the sorted form of its input. Stages the candidate does not need are left disabled and act as pass-through.

Top module: `bitsort_pipe`

## Requirements
- R1: In a stage enabled with two different lane numbers, the lower-numbered lane takes the AND of the two input bits and the higher-numbered lane takes the OR. The pair is stored in normalised form, so a write of (9, 2) acts exactly like a write of (2, 9).
- R2: All lanes outside the pair pass through unchanged. A stage also acts as pure pass-through when it is disabled (`cfg_on` = 0), when both of its lane numbers are equal, or when it is enabled with the same pair as the enabled stage just before it.
- R3: The latency from `in_vec`/`in_valid` to `out_vec`/`out_valid` is exactly STAGES clock cycles, and the pipeline accepts a new vector every cycle.
- R4: After reset every stage is disabled, so the block passes vectors through unchanged. `out_vec`, `out_valid` and `busy` are all 0.
- R5: `clr` is synchronous. On the cycle after `clr` is sampled high, every pipeline register is zero, so `out_vec` = 0, `out_valid` = 0 and `busy` = 0. Stage configuration is kept. A vector presented in the same cycle as `clr` is dropped.
- R6: A configuration write is taken only when `busy` = 0 and `in_valid` = 0 in the same cycle. A write attempted at any other time leaves every stage unchanged.
- R7: `busy` is high exactly while at least one pipeline register holds a valid vector, including the output register.
- R8: Every stage keeps the number of ones in the vector unchanged. Consider a network loaded with a full 16-lane sorter in its first stages and pass-through in the rest. Any input with z zeros comes out with lanes 0..z-1 at 0 and all higher lanes at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all pipeline registers |
| in_valid | input | 1 | Marks `in_vec` as a real vector |
| in_vec | input | LANES | Input bit vector, lane k on bit k |
| cfg_we | input | 1 | Stage write strobe |
| cfg_stage | input | SW | Stage number to write |
| cfg_a | input | IDXW | First lane number of the pair |
| cfg_b | input | IDXW | Second lane number of the pair |
| cfg_on | input | 1 | 1 enables the stage, 0 makes it pass-through |
| busy | output | 1 | A valid vector is in the pipeline |
| out_valid | output | 1 | Valid flag of the vector at the output |
| out_vec | output | LANES | Registered output of the last stage |

## Verification
A vector driven before a rising edge appears on `out_vec` and `out_valid` after the STAGES-th rising edge that follows. `busy` and the effect of `clr` both show up one edge after the stimulus. The bench drives and samples only on falling edges. It keeps a ring of expected entries indexed by the falling-edge count, and it compares the current outputs with the entry stored STAGES falling edges earlier. From the same ring it derives the expected `busy` and decides whether a write should be accepted. The default 16-lane, 80-stage network is loaded with a sorter, and all 65,536 input patterns are streamed through and checked against their sorted form.

// File: rtl/bitsort_pkg.sv
package bitsort_pkg;

   typedef enum logic [1:0] {
      LANE_PASS = 2'd0,
      LANE_MIN  = 2'd1,
      LANE_MAX  = 2'd2
   } lane_role_e;

   // Role a lane plays in one stage, given the stage's normalised pair.
   function automatic lane_role_e role_of(input int lane, input int lo,
                                          input int hi, input logic act);
      if (!act)       return LANE_PASS;
      if (lane == lo) return LANE_MIN;
      if (lane == hi) return LANE_MAX;
      return LANE_PASS;
   endfunction

endpackage

// File: rtl/bitsort_cfg.sv
module bitsort_cfg #(
   parameter int LANES  = 16,
   parameter int STAGES = 80,
   parameter int IDXW   = $clog2(LANES),
   parameter int SW     = $clog2(STAGES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [SW-1:0]                     wr_stage,
   input  logic [IDXW-1:0]                   wr_a,
   input  logic [IDXW-1:0]                   wr_b,
   input  logic                              wr_on,
   output logic [STAGES-1:0]                 act_o,
   output logic [STAGES-1:0][IDXW-1:0]       lo_o,
   output logic [STAGES-1:0][IDXW-1:0]       hi_o
);

   logic [IDXW-1:0] norm_lo, norm_hi;
   logic [STAGES-1:0] en_v;

   // Pairs are stored in ascending order so a stage never needs a swap.
   assign norm_lo = (wr_a < wr_b) ? wr_a : wr_b;
   assign norm_hi = (wr_a < wr_b) ? wr_b : wr_a;

   for (genvar s = 0; s < STAGES; s++) begin : g_ent
      logic            en_q;
      logic [IDXW-1:0] lo_q, hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q <= 1'b0;
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en && (wr_stage == SW'(s))) begin
            en_q <= wr_on;
            lo_q <= norm_lo;
            hi_q <= norm_hi;
         end
      end

      assign en_v[s] = en_q;
      assign lo_o[s] = lo_q;
      assign hi_o[s] = hi_q;

      // Degenerate pairs and back-to-back repeats collapse to pass-through.
      if (s == 0) begin : g_first
         assign act_o[s] = en_q && (lo_q != hi_q);
      end else begin : g_rest
         assign act_o[s] = en_q && (lo_q != hi_q) &&
                           !(en_v[s-1] && (lo_o[s-1] == lo_q) && (hi_o[s-1] == hi_q));
      end
   end

endmodule

// File: rtl/bitsort_stage.sv
module bitsort_stage
   import bitsort_pkg::*;
#(
   parameter int LANES = 16,
   parameter int IDXW  = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             act,
   input  logic [IDXW-1:0]  lo,
   input  logic [IDXW-1:0]  hi,
   input  logic [LANES-1:0] d_in,
   input  logic             v_in,
   output logic [LANES-1:0] d_out,
   output logic             v_out
);

   logic             bit_lo, bit_hi;
   logic [LANES-1:0] nxt;

   assign bit_lo = d_in[lo];
   assign bit_hi = d_in[hi];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      lane_role_e role;
      assign role   = role_of(k, int'(lo), int'(hi), act);
      assign nxt[k] = (role == LANE_MIN) ? (bit_lo & bit_hi) :
                      (role == LANE_MAX) ? (bit_lo | bit_hi) : d_in[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_out <= '0;
         v_out <= 1'b0;
      end else if (clr) begin
         d_out <= '0;
         v_out <= 1'b0;
      end else begin
         d_out <= nxt;
         v_out <= v_in;
      end
   end

endmodule

// File: rtl/bitsort_pipe.sv
module bitsort_pipe #(
   parameter int LANES  = 16,
   parameter int STAGES = 80,
   parameter int IDXW   = $clog2(LANES),
   parameter int SW     = (STAGES > 1) ? $clog2(STAGES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic [LANES-1:0] in_vec,
   input  logic             cfg_we,
   input  logic [SW-1:0]    cfg_stage,
   input  logic [IDXW-1:0]  cfg_a,
   input  logic [IDXW-1:0]  cfg_b,
   input  logic             cfg_on,
   output logic             busy,
   output logic             out_valid,
   output logic [LANES-1:0] out_vec
);

   if (LANES < 2) begin : g_bad_lanes
      $error("bitsort_pipe: LANES must be at least 2");
   end
   if ((1 << IDXW) != LANES) begin : g_bad_pow
      $error("bitsort_pipe: LANES must be a power of two");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("bitsort_pipe: STAGES must be at least 1");
   end

   logic [STAGES:0]                  vpipe;
   logic [STAGES:0][LANES-1:0]       dpipe;
   logic [STAGES-1:0]                act;
   logic [STAGES-1:0][IDXW-1:0]      lo_tab, hi_tab;
   logic                             wr_ok;

   assign vpipe[0] = in_valid;
   assign dpipe[0] = in_vec;

   assign busy  = |vpipe[STAGES:1];
   assign wr_ok = cfg_we && !busy && !in_valid && (int'(cfg_stage) < STAGES);

   bitsort_cfg #(
      .LANES (LANES),
      .STAGES(STAGES),
      .IDXW  (IDXW),
      .SW    (SW)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_stage(cfg_stage),
      .wr_a    (cfg_a),
      .wr_b    (cfg_b),
      .wr_on   (cfg_on),
      .act_o   (act),
      .lo_o    (lo_tab),
      .hi_o    (hi_tab)
   );

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      bitsort_stage #(
         .LANES(LANES),
         .IDXW (IDXW)
      ) u_stg (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr),
         .act  (act[s]),
         .lo   (lo_tab[s]),
         .hi   (hi_tab[s]),
         .d_in (dpipe[s]),
         .v_in (vpipe[s]),
         .d_out(dpipe[s+1]),
         .v_out(vpipe[s+1])
      );
   end

   assign out_vec   = dpipe[STAGES];
   assign out_valid = vpipe[STAGES];

endmodule

// File: rtl/bitsort_pipe_chk.sv
module bitsort_pipe_chk #(
   parameter int LANES  = 16,
   parameter int STAGES = 80,
   parameter int IDXW   = $clog2(LANES)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         clr,
   input logic                         in_valid,
   input logic                         cfg_we,
   input logic                         busy,
   input logic                         out_valid,
   input logic [LANES-1:0]             out_vec,
   input logic [STAGES:0]              vpipe,
   input logic [STAGES:0][LANES-1:0]   dpipe,
   input logic [STAGES-1:0]            act,
   input logic [STAGES-1:0][IDXW-1:0]  lo_tab,
   input logic [STAGES-1:0][IDXW-1:0]  hi_tab
);

   for (genvar s = 0; s < STAGES; s++) begin : g_chk
      a_r3_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (vpipe[s+1] == $past(vpipe[s])));

      a_r8_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> ($countones(dpipe[s+1]) == $countones($past(dpipe[s]))));

      a_r1_pair_ordered: assert property (@(posedge clk) disable iff (!rst_n)
         (act[s] && !clr) |=>
            (!dpipe[s+1][$past(lo_tab[s])] || dpipe[s+1][$past(hi_tab[s])]));
   end

   a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((out_vec == '0) && !out_valid && !busy));

   a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (busy || in_valid)) |=>
         ($stable(lo_tab) && $stable(hi_tab) && $stable(act)));

   a_r7_busy_covers_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

endmodule

bind bitsort_pipe bitsort_pipe_chk #(
   .LANES (LANES),
   .STAGES(STAGES),
   .IDXW  (IDXW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .in_valid (in_valid),
   .cfg_we   (cfg_we),
   .busy     (busy),
   .out_valid(out_valid),
   .out_vec  (out_vec),
   .vpipe    (vpipe),
   .dpipe    (dpipe),
   .act      (act),
   .lo_tab   (lo_tab),
   .hi_tab   (hi_tab)
);

// File: tb/bitsort_pipe_bench.sv
`timescale 1ns/1ps
module bitsort_pipe_bench;
   localparam int LANES  = 16;
   localparam int STAGES = 80;
   localparam int IDXW   = 4;
   localparam int SW     = 7;
   localparam int RING   = 128;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             in_valid = 1'b0;
   logic [LANES-1:0] in_vec = '0;
   logic             cfg_we = 1'b0;
   logic [SW-1:0]    cfg_stage = '0;
   logic [IDXW-1:0]  cfg_a = '0;
   logic [IDXW-1:0]  cfg_b = '0;
   logic             cfg_on = 1'b0;
   logic             busy, out_valid;
   logic [LANES-1:0] out_vec;

   always #4 clk = ~clk;

   bitsort_pipe #(.LANES(LANES), .STAGES(STAGES)) u_bitsort_pipe (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_vec(in_vec),
      .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_a(cfg_a), .cfg_b(cfg_b),
      .cfg_on(cfg_on), .busy(busy), .out_valid(out_valid), .out_vec(out_vec)
   );

   int checks = 0;
   int errors = 0;
   int n = 0;
   bit done = 0;

   logic [LANES-1:0] r_vec [RING];
   logic             r_v   [RING];
   logic             r_known [RING];
   string            r_tag [RING];

   bit m_en [STAGES];
   int m_lo [STAGES];
   int m_hi [STAGES];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h (cycle %0d)", tag, act, exp, n);
      end
   endtask

   function automatic logic [LANES-1:0] model(input logic [LANES-1:0] x);
      logic [LANES-1:0] y = x;
      for (int s = 0; s < STAGES; s++) begin
         if (m_en[s] && m_lo[s] != m_hi[s]) begin
            logic a = y[m_lo[s]];
            logic b = y[m_hi[s]];
            y[m_lo[s]] = a & b;
            y[m_hi[s]] = a | b;
         end
      end
      return y;
   endfunction

   function automatic logic [LANES-1:0] ideal(input logic [LANES-1:0] x);
      logic [LANES-1:0] r = '1;
      int z = LANES - $countones(x);
      r = r << z;
      return r;
   endfunction

   // One falling-edge step: check outputs due now, then drive the next inputs.
   task automatic step(input logic [LANES-1:0] vin, input logic vld, input logic c,
                       input logic we, input int stg, input int a, input int b,
                       input logic en, input bit use_ideal, input string tag);
      int idx = ((n - STAGES) % RING + RING) % RING;
      logic expb = 1'b0;
      if (r_known[idx]) chk(r_tag[idx], 32'(out_vec), 32'(r_vec[idx]));
      chk("R3", 32'(out_valid), 32'(r_v[idx]));
      for (int k = 1; k <= STAGES; k++)
         expb |= r_v[((n - k) % RING + RING) % RING];
      chk("R7", 32'(busy), 32'(expb));
      in_vec = vin; in_valid = vld; clr = c;
      cfg_we = we; cfg_stage = SW'(stg); cfg_a = IDXW'(a); cfg_b = IDXW'(b); cfg_on = en;
      if (c) begin
         for (int k = 0; k < RING; k++) begin
            r_vec[k] = '0; r_v[k] = 1'b0; r_known[k] = 1'b1; r_tag[k] = "R5";
         end
      end else begin
         r_vec[n % RING]   = use_ideal ? ideal(vin) : model(vin);
         r_v[n % RING]     = vld;
         r_known[n % RING] = vld;
         r_tag[n % RING]   = tag;
      end
      // R6: the model takes a write only when the pipe is idle.
      if (we && !vld && !expb && stg < STAGES) begin
         m_en[stg] = en;
         m_lo[stg] = (a < b) ? a : b;
         m_hi[stg] = (a < b) ? b : a;
      end
      @(negedge clk);
      n++;
   endtask

   task automatic idle(input int cnt, input string tag);
      for (int k = 0; k < cnt; k++) step('0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      for (int k = 0; k < RING; k++) begin
         r_vec[k] = '0; r_v[k] = 1'b0; r_known[k] = 1'b1; r_tag[k] = "R4";
      end
      for (int s = 0; s < STAGES; s++) begin
         m_en[s] = 0; m_lo[s] = 0; m_hi[s] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state, and identity transfer with every stage disabled
      idle(4, "R4");
      for (int k = 0; k < 20; k++) step(16'(k * 16'h0b3d + 5), 1, 0, 0, 0, 0, 0, 0, 0, "R4");
      idle(STAGES + 2, "R4");

      // load a 16-lane odd-even merge sorter, trailing stages stay pass-through
      begin
         int s = 0;
         for (int p = 1; p < LANES; p += p)
            for (int k = p; k > 0; k /= 2)
               for (int j = k % p; j + k < LANES; j += 2 * k)
                  for (int i = 0; i < k && i < LANES - j - k; i++)
                     if ((i + j) / (2 * p) == (i + j + k) / (2 * p)) begin
                        step('0, 0, 0, 1, s, i + j, i + j + k, 1, 0, "R4");
                        s++;
                     end
      end

      // R6: a write alongside in_valid is dropped
      step(16'h0000, 1, 0, 1, 0, 0, 15, 1, 1, "R6");
      // R8: every 16-bit pattern comes out sorted
      for (int v = 1; v < 65536; v++) begin
         if (v == 1000) step(16'(v), 1, 0, 1, 5, 3, 4, 0, 1, "R6");
         else           step(16'(v), 1, 0, 0, 0, 0, 0, 0, 1, "R8");
      end
      idle(STAGES + 2, "R6");

      // R1, R2: reversed pair, equal lanes, repeated pair, disabled stage
      for (int s = 0; s < STAGES; s++) begin
         case (s)
            0:       step('0, 0, 0, 1, s, 5, 5, 1, 0, "R2");
            1:       step('0, 0, 0, 1, s, 9, 2, 1, 0, "R2");
            2:       step('0, 0, 0, 1, s, 2, 9, 1, 0, "R2");
            3:       step('0, 0, 0, 1, s, 0, 1, 0, 0, "R2");
            4:       step('0, 0, 0, 1, s, 15, 0, 1, 0, "R2");
            5:       step('0, 0, 0, 1, s, 7, 8, 1, 0, "R2");
            6:       step('0, 0, 0, 1, s, 12, 3, 1, 0, "R2");
            default: step('0, 0, 0, 1, s, 1, 6, 0, 0, "R2");
         endcase
      end
      begin
         logic [15:0] lf = 16'hace1;
         for (int k = 0; k < 300; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            // R5: a clear in the middle of the stream
            if (k == 150) step(lf, 1, 1, 0, 0, 0, 0, 0, 0, "R5");
            else          step(lf, (k % 3) != 0, 0, 0, 0, 0, 0, 0, 0, "R1 R2");
         end
      end
      idle(STAGES + 2, "R2");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule